// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This unit forms the memory address for a single-register load or store and the value the base register should take afterwards. A request presents a base value, one of three offset sources (a zero-extended immediate, an index register value, or that index value shifted left by a given amount), a direction flag choosing whether the offset is added or subtracted, an indexing flag choosing whether the offset applies before or after the access, and a writeback flag.

The result is registered and appears one clock after the request. It arrives with a one-cycle request strobe toward a simple memory port, the access address, the updated base value and a base write enable for the register file. The index register value is only read and is never written back. A plain register-indirect access is requested as a pre-indexed immediate access with a zero offset. All arithmetic is 32-bit and wraps modulo 2^32.

Top module: `ls_addr_gen`

## Requirements
- R1: While reset is asserted and until the first request after it, `mem_req` and `base_we` are 0 and `mem_addr` and `base_new` are 0.
- R2: `mem_req` is 1 in exactly the cycle after each cycle in which `req_valid` is 1, and 0 otherwise. Back-to-back requests give back-to-back results in order.
- R3: With `ofs_mode` = 0, the offset is `imm_off` zero-extended to 32 bits.
- R4: With `ofs_mode` = 1, the offset is `idx_val` unshifted.
- R5: With `ofs_mode` = 2 or 3, the offset is `idx_val` shifted left by `shamt` (0..31), and bits shifted past bit 31 are lost. A shift of 2 multiplies by 4 and a shift of 3 multiplies by 8.
- R6: `sub_sel` = 1 gives base minus offset and `sub_sel` = 0 gives base plus offset.
- R7: Pre-indexed (`pre_sel` = 1) without writeback (`wb_req` = 0): `mem_addr` = base ± offset, `base_we` = 0, and `base_new` equals the base that was presented.
- R8: Pre-indexed with writeback (`wb_req` = 1): `mem_addr` = base ± offset, `base_we` = 1, and `base_new` equals `mem_addr`.
- R9: Post-indexed (`pre_sel` = 0): `mem_addr` equals the unmodified base, `base_new` = base ± offset, and `base_we` = 1 whatever `wb_req` is.
- R10: In a cycle with no result (`mem_req` = 0), `base_we` is 0 and `mem_addr` and `base_new` keep their last values.
- R11: Address sums and differences wrap modulo 2^32 on overflow and underflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe, one cycle per access |
| base_val | input | 32 | Base register value |
| imm_off | input | 12 | Immediate offset, zero-extended |
| idx_val | input | 32 | Index register value |
| shamt | input | 5 | Left shift applied to the index in scaled mode |
| sub_sel | input | 1 | 1 subtracts the offset, 0 adds it |
| pre_sel | input | 1 | 1 pre-indexed, 0 post-indexed |
| wb_req | input | 1 | Base writeback request for pre-indexed accesses |
| ofs_mode | input | 2 | Offset source: 0 immediate, 1 register, 2 or 3 scaled register |
| mem_req | output | 1 | Memory request strobe, one cycle after `req_valid` |
| mem_addr | output | 32 | Access address |
| base_new | output | 32 | Value to write to the base register |
| base_we | output | 1 | Base register write enable |

## Verification
Every result of this block is due exactly one clock after the cycle in which `req_valid` was high. The address, the new base and the write enable all appear in the same cycle as the `mem_req` strobe. The bench drives requests on the falling edge and pushes the expected triple into a queue. A monitor samples on each falling edge and pops one item only when `mem_req` is high, so a result that comes a cycle early or late, or that is missing, is caught as a mismatch or as a leftover or empty queue. In idle cycles the monitor checks that the held outputs have not moved and that `base_we` stays low.

// File: rtl/ls_addr_pkg.sv
package ls_addr_pkg;
  localparam int unsigned ADDR_W = 32;

  // Offset source selection
  typedef enum logic [1:0] {
    OFS_IMM     = 2'd0,
    OFS_REG     = 2'd1,
    OFS_SCL     = 2'd2,
    OFS_SCL_ALT = 2'd3
  } ofs_mode_e;
endpackage

// File: rtl/ls_rst_sync.sv
module ls_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/ls_offset_sel.sv
module ls_offset_sel
  import ls_addr_pkg::*;
#(
  parameter int unsigned AW    = ADDR_W,
  parameter int unsigned IMM_W = 12,
  parameter int unsigned SH_W  = $clog2(AW)
) (
  input  logic [1:0]       mode,
  input  logic [IMM_W-1:0] imm,
  input  logic [AW-1:0]    idx,
  input  logic [SH_W-1:0]  shamt,
  output logic [AW-1:0]    off
);
  logic [AW-1:0] imm_ext;

  generate
    if (IMM_W < AW) begin : g_imm_pad
      assign imm_ext = {{(AW-IMM_W){1'b0}}, imm};
    end else begin : g_imm_trim
      assign imm_ext = imm[AW-1:0];
    end
  endgenerate

  always_comb begin
    unique case (ofs_mode_e'(mode))
      OFS_IMM:     off = imm_ext;
      OFS_REG:     off = idx;
      OFS_SCL,
      OFS_SCL_ALT: off = idx << shamt;
      default:     off = idx << shamt;
    endcase
  end
endmodule

// File: rtl/ls_addr_add.sv
module ls_addr_add #(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] off,
  input  logic          sub,
  input  logic          pre,
  input  logic          wb,
  output logic [AW-1:0] addr,
  output logic [AW-1:0] nbase,
  output logic          we
);
  logic [AW-1:0] moved;

  // Single adder; subtraction by two's complement of the offset
  always_comb begin
    moved = base + (sub ? (~off + {{(AW-1){1'b0}}, 1'b1}) : off);
  end

  always_comb begin
    if (pre) begin
      addr  = moved;
      we    = wb;
      nbase = wb ? moved : base;
    end else begin
      addr  = base;
      we    = 1'b1;
      nbase = moved;
    end
  end
endmodule

// File: rtl/ls_out_reg.sv
module ls_out_reg #(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          srst_n,
  input  logic          load,
  input  logic [AW-1:0] addr_d,
  input  logic [AW-1:0] nbase_d,
  input  logic          we_d,
  output logic          req_q,
  output logic [AW-1:0] addr_q,
  output logic [AW-1:0] nbase_q,
  output logic          we_q
);
  logic          req_n;
  logic          we_n;
  logic [AW-1:0] addr_n;
  logic [AW-1:0] nbase_n;

  always_comb begin
    req_n   = load;
    we_n    = load & we_d;
    addr_n  = load ? addr_d  : addr_q;
    nbase_n = load ? nbase_d : nbase_q;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      req_q   <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      nbase_q <= '0;
    end else begin
      req_q   <= req_n;
      we_q    <= we_n;
      addr_q  <= addr_n;
      nbase_q <= nbase_n;
    end
  end
endmodule

// File: rtl/ls_addr_gen.sv
module ls_addr_gen
  import ls_addr_pkg::*;
#(
  parameter int unsigned AW    = ADDR_W,
  parameter int unsigned IMM_W = 12,
  parameter int unsigned SH_W  = $clog2(AW)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [AW-1:0]    base_val,
  input  logic [IMM_W-1:0] imm_off,
  input  logic [AW-1:0]    idx_val,
  input  logic [SH_W-1:0]  shamt,
  input  logic             sub_sel,
  input  logic             pre_sel,
  input  logic             wb_req,
  input  logic [1:0]       ofs_mode,
  output logic             mem_req,
  output logic [AW-1:0]    mem_addr,
  output logic [AW-1:0]    base_new,
  output logic             base_we
);
  logic          srst_n;
  logic [AW-1:0] off_w;
  logic [AW-1:0] addr_w;
  logic [AW-1:0] nbase_w;
  logic          we_w;

  ls_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  ls_offset_sel #(.AW(AW), .IMM_W(IMM_W), .SH_W(SH_W)) u_ofs (
    .mode  (ofs_mode),
    .imm   (imm_off),
    .idx   (idx_val),
    .shamt (shamt),
    .off   (off_w)
  );

  ls_addr_add #(.AW(AW)) u_add (
    .base  (base_val),
    .off   (off_w),
    .sub   (sub_sel),
    .pre   (pre_sel),
    .wb    (wb_req),
    .addr  (addr_w),
    .nbase (nbase_w),
    .we    (we_w)
  );

  ls_out_reg #(.AW(AW)) u_reg (
    .clk     (clk),
    .srst_n  (srst_n),
    .load    (req_valid),
    .addr_d  (addr_w),
    .nbase_d (nbase_w),
    .we_d    (we_w),
    .req_q   (mem_req),
    .addr_q  (mem_addr),
    .nbase_q (base_new),
    .we_q    (base_we)
  );
endmodule

module ls_addr_gen_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [AW-1:0] base_val,
  input logic          pre_sel,
  input logic          wb_req,
  input logic          mem_req,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] base_new,
  input logic          base_we
);
  always @(negedge clk) begin
    if (!rst_n) begin
      p_reset_idle_r1: assert (!mem_req && !base_we);
    end
  end

  p_req_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> mem_req);

  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !mem_req);

  p_pre_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && pre_sel && !wb_req) |=> (!base_we && base_new == $past(base_val)));

  p_pre_wb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && pre_sel && wb_req) |=> (base_we && base_new == mem_addr));

  p_post_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !pre_sel) |=> (base_we && mem_addr == $past(base_val)));

  p_we_with_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    base_we |-> mem_req);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(mem_addr) && $stable(base_new)));
endmodule

bind ls_addr_gen ls_addr_gen_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (srst_n),
  .req_valid (req_valid),
  .base_val  (base_val),
  .pre_sel   (pre_sel),
  .wb_req    (wb_req),
  .mem_req   (mem_req),
  .mem_addr  (mem_addr),
  .base_new  (base_new),
  .base_we   (base_we)
);

// File: tb/sim_ls_addr_gen.sv
module sim_ls_addr_gen;
  typedef struct {
    logic [31:0] addr;
    logic [31:0] nb;
    logic        we;
    string       tag;
  } exp_t;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] base_val;
  logic [11:0] imm_off;
  logic [31:0] idx_val;
  logic [4:0]  shamt;
  logic        sub_sel;
  logic        pre_sel;
  logic        wb_req;
  logic [1:0]  ofs_mode;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic [31:0] base_new;
  logic        base_we;

  int   n_checks = 0;
  int   n_fail   = 0;
  bit   mon_on   = 0;
  bit   have_last = 0;
  bit   done     = 0;
  logic [31:0] last_addr;
  logic [31:0] last_nb;
  exp_t sb[$];

  ls_addr_gen u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .base_val(base_val),
    .imm_off(imm_off), .idx_val(idx_val), .shamt(shamt), .sub_sel(sub_sel),
    .pre_sel(pre_sel), .wb_req(wb_req), .ofs_mode(ofs_mode),
    .mem_req(mem_req), .mem_addr(mem_addr), .base_new(base_new), .base_we(base_we)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  endtask

  // Driver: present one request at a falling edge and push its expectation
  task automatic send(input logic [31:0] b, input logic [11:0] imm, input logic [31:0] idx,
                      input logic [4:0] sh, input logic sub, input logic pre,
                      input logic wb, input logic [1:0] mode, input string tag);
    exp_t e;
    logic [31:0] off;
    logic [31:0] moved;
    case (mode)
      2'd0:    off = {20'd0, imm};
      2'd1:    off = idx;
      default: off = idx << sh;
    endcase
    moved = sub ? (b - off) : (b + off);
    if (pre) begin
      e.addr = moved;
      e.we   = wb;
      e.nb   = wb ? moved : b;
    end else begin
      e.addr = b;
      e.we   = 1'b1;
      e.nb   = moved;
    end
    e.tag = tag;
    req_valid = 1'b1; base_val = b; imm_off = imm; idx_val = idx; shamt = sh;
    sub_sel = sub; pre_sel = pre; wb_req = wb; ofs_mode = mode;
    sb.push_back(e);
    @(negedge clk);
  endtask

  task automatic quiet(input int n);
    req_valid = 1'b0;
    base_val = 32'hDEAD_BEEF; idx_val = 32'h1234_5678; imm_off = 12'hABC;
    repeat (n) @(negedge clk);
  endtask

  // Monitor: results are due one cycle after the request
  always @(negedge clk) begin
    if (mon_on) begin
      if (mem_req) begin
        if (sb.size() == 0) begin
          check(1'b0, "R2 unexpected result", {31'd0, mem_req}, 32'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(mem_addr == e.addr, {e.tag, " addr"}, mem_addr, e.addr);
          check(base_new == e.nb, {e.tag, " base_new"}, base_new, e.nb);
          check(base_we == e.we, {e.tag, " base_we"}, {31'd0, base_we}, {31'd0, e.we});
        end
        last_addr = mem_addr;
        last_nb   = base_new;
        have_last = 1;
      end else if (have_last) begin
        check(!base_we, "R10 we idle", {31'd0, base_we}, 32'd0);
        check(mem_addr == last_addr && base_new == last_nb, "R10 hold", mem_addr, last_addr);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; base_val = '0; imm_off = '0; idx_val = '0; shamt = '0;
    sub_sel = 1'b0; pre_sel = 1'b1; wb_req = 1'b0; ofs_mode = 2'd0;
    repeat (3) @(negedge clk);
    check(!mem_req && !base_we && mem_addr == 0 && base_new == 0, "R1 in reset", mem_addr, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!mem_req && !base_we && mem_addr == 0 && base_new == 0, "R1 after release", mem_addr, 32'd0);
    mon_on = 1;

    send(32'h0000_0200, 12'd0,   32'd0, 5'd0, 1'b0, 1'b1, 1'b0, 2'd0, "R3 R7 indirect");
    quiet(2);
    send(32'h0000_00C8, 12'd12,  32'd0, 5'd0, 1'b0, 1'b1, 1'b0, 2'd0, "R3 R7 imm add");
    send(32'h0000_00C8, 12'd8,   32'd0, 5'd0, 1'b1, 1'b1, 1'b0, 2'd0, "R3 R6 imm sub");
    send(32'h0000_1000, 12'hFFF, 32'd0, 5'd0, 1'b0, 1'b1, 1'b0, 2'd0, "R3 max imm");
    quiet(1);
    send(32'h0000_1000, 12'd0, 32'h0000_0040, 5'd7, 1'b0, 1'b1, 1'b1, 2'd1, "R4 R8 reg wb");
    send(32'h0000_1000, 12'd0, 32'h0000_0040, 5'd0, 1'b1, 1'b1, 1'b1, 2'd1, "R4 R6 reg sub wb");
    send(32'h0000_2000, 12'd0, 32'h0000_0003, 5'd2, 1'b0, 1'b1, 1'b0, 2'd2, "R5 scaled x4");
    send(32'h0000_2000, 12'd0, 32'h0000_0003, 5'd3, 1'b1, 1'b1, 1'b1, 2'd2, "R5 R8 scaled x8 sub");
    send(32'h0000_2000, 12'd0, 32'h0000_0003, 5'd31, 1'b0, 1'b1, 1'b0, 2'd3, "R5 mode3 shift31");
    quiet(3);
    send(32'h0000_3000, 12'd4, 32'd0, 5'd0, 1'b0, 1'b0, 1'b0, 2'd0, "R9 post imm nowb");
    send(32'h0000_3000, 12'd0, 32'h10, 5'd2, 1'b1, 1'b0, 1'b1, 2'd2, "R9 post scaled wb");
    send(32'h0000_3000, 12'd0, 32'h24, 5'd0, 1'b0, 1'b0, 1'b0, 2'd1, "R9 post reg");
    quiet(2);
    send(32'hFFFF_FFF0, 12'h20, 32'd0, 5'd0, 1'b0, 1'b1, 1'b1, 2'd0, "R11 wrap up");
    send(32'h0000_0010, 12'h20, 32'd0, 5'd0, 1'b1, 1'b1, 1'b0, 2'd0, "R11 wrap down");
    send(32'h0000_0004, 12'd0, 32'h8, 5'd0, 1'b1, 1'b0, 1'b0, 2'd1, "R11 R9 post wrap");
    quiet(3);

    check(sb.size() == 0, "R2 all results seen", sb.size(), 32'd0);
    finish_run();
  end
endmodule